// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block derives the two timing strobes a serial receiver and transmitter need from the peripheral clock. The first is the oversampling strobe and the second is the bit strobe. The divisor has an integer part and a 6-bit fraction in steps of 1/64. The fraction is spread over successive periods by an accumulator. Each period therefore lasts either the integer count or one cycle more, and the average period lands on the programmed fractional value.

Software computes the divisor once. The divisor equals the clock frequency over the baud rate times the oversampling ratio, with the fraction rounded to the nearest 1/64. Software writes the integer and the fraction together with a single write strobe. A mode input selects 16 or 8 oversampling strobes per bit. An enable input gates the whole generator.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the stored divisor is zero, so neither strobe asserts, even with the enable high, until a divisor is written.
- R2: With a fraction of 0 and an integer N of 2 or more, the oversampling strobe is one cycle wide and recurs every N cycles.
- R3: A write through `scale_wr_i` restarts the generator. The first oversampling strobe is visible N cycles after the clock edge that captured the write.
- R4: Number the periods k = 0, 1, 2, and so on from a restart, with fraction F. Period k lasts N + floor((k+1)F/64) - floor(kF/64) cycles. Any 64 consecutive periods from a restart therefore total 64N + F cycles.
- R5: A stored integer of 0 stops all strobes, whatever the fraction is.
- R6: With `osr_sel_i` = 0 the bit strobe asserts together with every 16th oversampling strobe after a restart. With `osr_sel_i` = 1 it asserts with every 8th. It never asserts without an oversampling strobe.
- R7: While `en_i` is low, no strobe asserts and the period counter and accumulator are held at their restart values. The first cycle with `en_i` high counts as cycle 1 of period 0.
- R8: A write in the middle of a period discards the partial period, the accumulator and the bit count, and timing then follows R3 and R4 with the new values.
- R9: With N = 1 and fraction 0 the oversampling strobe is high in every enabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Generator enable |
| scale_wr_i | input | 1 | Write strobe that captures both divisor fields |
| int_div_i | input | INT_W | Integer part of the divisor |
| frac_div_i | input | 6 | Fractional part of the divisor, in units of 1/64 |
| osr_sel_i | input | 1 | Oversampling select: 0 gives 16x, 1 gives 8x |
| osr_tick_o | output | 1 | One-cycle oversampling strobe |
| bit_tick_o | output | 1 | One-cycle bit strobe |

## Verification
Both strobes are decoded without a register from the counter state. Each strobe is therefore visible in the same cycle the counter reaches its terminal value. After the edge that captures a write, the first oversampling strobe falls in cycle N, counting that edge's following cycle as 1. Each later strobe falls exactly one period length after the previous one.

The bench drives inputs and samples outputs on the falling edge. It counts cycles from the capturing edge and compares every measured gap with the R4 formula, which it evaluates itself. The bit strobe is checked on every oversampling strobe against a running count modulo 16 or 8.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
  localparam int FRAC_W  = 6;
  localparam int OSR_MAX = 16;
  localparam int BCNT_W  = $clog2(OSR_MAX);

  typedef logic [FRAC_W-1:0] frac_t;

  typedef enum logic {
    OSR_X16 = 1'b0,
    OSR_X8  = 1'b1
  } osr_mode_e;
endpackage

// File: rtl/frac_baud_div.sv
module frac_baud_div
  import frac_baud_pkg::*;
#(
  parameter int INT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [INT_W-1:0] start_int_i,
  input  frac_t            start_frac_i,
  input  logic [INT_W-1:0] int_i,
  input  frac_t            frac_i,
  output logic             tick_o
);
  logic [INT_W-1:0] cnt_q, last_q;
  frac_t            acc_q;
  logic [FRAC_W:0]  sum;

  assign sum    = {1'b0, acc_q} + {1'b0, frac_i};
  assign tick_o = run_i && (cnt_q == last_q);

  // accumulator preloaded with the fraction: period k carries on add k+1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      last_q <= '1;
    end else if (restart_i) begin
      cnt_q  <= '0;
      acc_q  <= start_frac_i;
      last_q <= start_int_i - 1'b1;
    end else if (tick_o) begin
      cnt_q  <= '0;
      acc_q  <= sum[FRAC_W-1:0];
      last_q <= int_i - 1'b1 + INT_W'(sum[FRAC_W]);
    end else if (run_i) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= last_q); // R4

  AST_MIN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !restart_i && int_i > 1) |=> !tick_o); // R2

  AST_EVERY_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !restart_i && int_i == 1 && frac_i == '0) |=> (tick_o || !run_i)); // R9
endmodule

// File: rtl/frac_baud_bits.sv
module frac_baud_bits
  import frac_baud_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic osr_tick_i,
  input  logic osr_sel_i,
  output logic bit_tick_o
);
  localparam logic [BCNT_W-1:0] LAST16 = BCNT_W'(OSR_MAX - 1);
  localparam logic [BCNT_W-1:0] LAST8  = BCNT_W'(OSR_MAX / 2 - 1);

  logic [BCNT_W-1:0] bcnt_q, last;

  assign last       = (osr_mode_e'(osr_sel_i) == OSR_X8) ? LAST8 : LAST16;
  // >= keeps a mode change mid-bit from wrapping the counter
  assign bit_tick_o = osr_tick_i && (bcnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          bcnt_q <= '0;
    else if (clear_i)     bcnt_q <= '0;
    else if (bit_tick_o)  bcnt_q <= '0;
    else if (osr_tick_i)  bcnt_q <= bcnt_q + 1'b1;
  end

  AST_BIT_WITH_OSR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> osr_tick_i); // R6

  AST_BIT_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |=> !bit_tick_o); // R6
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import frac_baud_pkg::*;
#(
  parameter int INT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             scale_wr_i,
  input  logic [INT_W-1:0] int_div_i,
  input  logic [5:0]       frac_div_i,
  input  logic             osr_sel_i,
  output logic             osr_tick_o,
  output logic             bit_tick_o
);
  logic [INT_W-1:0] int_q, start_int;
  frac_t            frac_q, start_frac;
  logic             run, restart;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q  <= '0;
      frac_q <= '0;
    end else if (scale_wr_i) begin
      int_q  <= int_div_i;
      frac_q <= frac_div_i;
    end
  end

  assign run        = en_i && (int_q != '0);
  assign restart    = scale_wr_i || !en_i;
  assign start_int  = scale_wr_i ? int_div_i  : int_q;
  assign start_frac = scale_wr_i ? frac_div_i : frac_q;

  frac_baud_div #(.INT_W(INT_W)) u_div (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run),
    .restart_i    (restart),
    .start_int_i  (start_int),
    .start_frac_i (start_frac),
    .int_i        (int_q),
    .frac_i       (frac_q),
    .tick_o       (osr_tick_o)
  );

  frac_baud_bits u_bits (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (restart),
    .osr_tick_i (osr_tick_o),
    .osr_sel_i  (osr_sel_i),
    .bit_tick_o (bit_tick_o)
  );

  AST_WR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scale_wr_i && int_div_i > 1) |=> !osr_tick_o); // R3

  AST_IDLE_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !(osr_tick_o || bit_tick_o)); // R7

  AST_ZERO_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scale_wr_i && int_div_i == '0) |=> !osr_tick_o); // R5
endmodule

// File: tb/frac_baud_gen_test.sv
`timescale 1ns/1ps
module frac_baud_gen_test;
  localparam int INT_W = 16;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             en_i = 1'b0;
  logic             scale_wr_i = 1'b0;
  logic [INT_W-1:0] int_div_i = '0;
  logic [5:0]       frac_div_i = '0;
  logic             osr_sel_i = 1'b0;
  logic             osr_tick_o, bit_tick_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  frac_baud_gen #(.INT_W(INT_W)) uut (
    .clk_i, .rst_ni, .en_i, .scale_wr_i, .int_div_i, .frac_div_i,
    .osr_sel_i, .osr_tick_o, .bit_tick_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int n, input int f, input int k);
    return n + ((k + 1) * f) / 64 - (k * f) / 64;
  endfunction

  // leaves the bench at cycle 1 after the capturing edge
  task automatic wr(input int n, input int f);
    @(negedge clk_i);
    int_div_i  = INT_W'(n);
    frac_div_i = 6'(f);
    scale_wr_i = 1'b1;
    @(negedge clk_i);
    scale_wr_i = 1'b0;
  endtask

  task automatic run_periods(input int n, input int f, input int np, input string req);
    int total = 0;
    int exp_total = 0;
    for (int k = 0; k < np; k++) begin
      int c = 0;
      bit found = 0;
      while (!found && c < 300) begin
        c++;
        if (osr_tick_o) found = 1;
        @(negedge clk_i);
      end
      chk(found && c == exp_len(n, f, k), req, c, exp_len(n, f, k));
      total     += c;
      exp_total += exp_len(n, f, k);
    end
    if (np == 64) chk(total == 64 * n + f, req, total, 64 * n + f);
    else          chk(total == exp_total, req, total, exp_total);
  endtask

  task automatic quiet(input int cyc, input string req);
    int seen = 0;
    for (int i = 0; i < cyc; i++) begin
      if (osr_tick_o || bit_tick_o) seen++;
      @(negedge clk_i);
    end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic t_reset;
    en_i = 1'b1;
    @(negedge clk_i);
    quiet(60, "R1");
  endtask

  task automatic t_int_only;
    wr(4, 0);  run_periods(4, 0, 10, "R2");
    wr(7, 0);  run_periods(7, 0, 5, "R3");
    wr(1, 0);  run_periods(1, 0, 20, "R9");
  endtask

  task automatic t_frac;
    wr(3, 37); run_periods(3, 37, 64, "R4");
    wr(2, 63); run_periods(2, 63, 64, "R4");
    wr(1, 1);  run_periods(1, 1, 64, "R4");
    wr(5, 32); run_periods(5, 32, 64, "R4");
  endtask

  task automatic t_zero;
    wr(0, 25);
    quiet(200, "R5");
  endtask

  task automatic t_bits(input bit sel);
    int ratio = sel ? 8 : 16;
    int nosr = 0;
    int nbit = 0;
    int bad = 0;
    osr_sel_i = sel;
    wr(2, 0);
    for (int i = 0; i < 2 * 3 * 16 + 4; i++) begin
      if (bit_tick_o && !osr_tick_o) bad++;
      if (osr_tick_o) begin
        nosr++;
        if (bit_tick_o != (nosr % ratio == 0)) bad++;
        if (bit_tick_o) nbit++;
      end
      @(negedge clk_i);
    end
    chk(bad == 0, "R6", bad, 0);
    chk(nbit == nosr / ratio, "R6", nbit, nosr / ratio);
    osr_sel_i = 1'b0;
  endtask

  task automatic t_enable;
    wr(3, 20);
    run_periods(3, 20, 5, "R7");
    en_i = 1'b0;
    quiet(30, "R7");
    en_i = 1'b1;
    run_periods(3, 20, 12, "R7");
  endtask

  task automatic t_rewrite;
    wr(9, 0);
    repeat (5) @(negedge clk_i);
    wr(4, 48);
    run_periods(4, 48, 16, "R8");
    osr_sel_i = 1'b1;
    wr(2, 0);
    repeat (11) @(negedge clk_i);
    wr(3, 0);
    begin
      int nosr = 0;
      int first_bit = 0;
      for (int i = 0; i < 40 && first_bit == 0; i++) begin
        if (osr_tick_o) begin
          nosr++;
          if (bit_tick_o) first_bit = nosr;
        end
        @(negedge clk_i);
      end
      chk(first_bit == 8, "R8", first_bit, 8);
    end
    osr_sel_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_int_only();
    t_frac();
    t_zero();
    t_bits(1'b0);
    t_bits(1'b1);
    t_enable();
    t_rewrite();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule